// File: doc/BRIEF.md
# Duty-Cycle Sleep-Depth Selector

This block sits next to the power manager of a duty-cycled core. The core runs for a while and then sleeps, and one full period of running plus sleeping has a fixed length. A cycle counter measures how long the core has been active in the current period. When the core asks to sleep, the block takes the fixed period minus that count as the expected sleep length. It then picks the sleep depth.

A light sleep, which only stops the clock, costs almost no entry overhead, so it is the default. A deep sleep, which removes power, takes tens of cycles to pay back its entry cost. It is chosen only when the expected sleep is longer than a programmable break-even threshold. The threshold resets to 55 cycles. If no sleep time is left, the block asks for no sleep at all and the core stays running. Busy polling is never chosen.

The decision is registered. It is presented with a single-cycle valid strobe on each new sleep request, together with the predicted sleep length.

Top module: `sleep_depth_sel`

## Requirements
- R1: After reset, valid_o is 0, sleep_o is 0, mode_o is 0 and off_pred_o is 0.
- R2: On a sleep request, off_pred_o equals period_i minus the number of clock edges at which core_active_i was 1 in the latest active stretch.
- R3: The active count restarts at a new stretch: the first edge with core_active_i at 1 after an edge with it at 0 sets the count to 1.
- R4: The active count saturates at period_i, so off_pred_o is never negative and reads 0 once the stretch reaches or passes the period.
- R5: When off_pred_o is 0, sleep_o is 0 (no sleep is requested and the core stays active). Otherwise sleep_o is 1.
- R6: mode_o is 1 (deep sleep) when off_pred_o is strictly greater than the threshold, and 0 (light sleep) otherwise.
- R7: The threshold resets to 55 and is loaded from thr_data_i at any edge with thr_we_i at 1. Later decisions use the new value.
- R8: valid_o is 1 for exactly one cycle after each rising edge of sleep_req_i. It stays 0 while the request is held. mode_o, sleep_o and off_pred_o change only together with valid_o.
- R9: While core_active_i is 0, the active count holds its value, so a request made after idle cycles still sees the stretch that preceded them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| period_i | input | CNT_W | Fixed duty-cycle period in cycles |
| core_active_i | input | 1 | Core is running in this cycle |
| sleep_req_i | input | 1 | Sleep request from the core; its rising edge triggers a decision |
| thr_we_i | input | 1 | Load the break-even threshold |
| thr_data_i | input | CNT_W | New threshold value |
| valid_o | output | 1 | One-cycle strobe marking a new decision |
| sleep_o | output | 1 | 1: enter a sleep mode, 0: stay active |
| mode_o | output | 1 | 0: light sleep, 1: deep sleep |
| off_pred_o | output | CNT_W | Predicted sleep length in cycles |

## Verification
The bench builds the block with CNT_W set to 8 and keeps the default threshold of 55. With this width, a full-scale period of 255 can be driven to saturation in a few hundred cycles, and stretches longer than the period are easy to reach. It also puts the threshold boundary on both sides: a predicted sleep of exactly 55 gives light sleep and 56 gives deep sleep. Both the reset threshold and a reprogrammed threshold are tested this way.

// File: rtl/sds_pkg.sv
package sds_pkg;
  typedef enum logic {
    MODE_LIGHT = 1'b0,
    MODE_DEEP  = 1'b1
  } sleep_mode_e;
endpackage

// File: rtl/on_time_ctr.sv
module on_time_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic           active_q;
  logic [CNT_W:0] nxt;

  // first active edge of a stretch loads 1, later ones add 1
  always_comb begin
    nxt = active_q ? ({1'b0, cnt_o} + 1'b1) : {{CNT_W{1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_o    <= '0;
    end else begin
      active_q <= active_i;
      if (active_i) begin
        if (nxt > {1'b0, period_i}) cnt_o <= period_i;
        else                        cnt_o <= nxt[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/thr_reg.sv
module thr_reg #(
  parameter int CNT_W     = 16,
  parameter int THR_RESET = 55
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CNT_W-1:0] data_i,
  output logic [CNT_W-1:0] thr_o
);
  localparam logic [CNT_W-1:0] ThrInit = CNT_W'(THR_RESET);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   thr_o <= ThrInit;
    else if (we_i) thr_o <= data_i;
  end
endmodule

// File: rtl/depth_decider.sv
module depth_decider
  import sds_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] thr_i,
  output logic             valid_o,
  output logic             sleep_o,
  output sleep_mode_e      mode_o,
  output logic [CNT_W-1:0] off_o
);
  logic             req_q;
  logic             req_rise;
  logic [CNT_W-1:0] off_d;

  assign req_rise = req_i & ~req_q;
  // clamp so a lowered period never yields a wrapped value
  assign off_d    = (period_i > cnt_i) ? (period_i - cnt_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      valid_o <= 1'b0;
      sleep_o <= 1'b0;
      mode_o  <= MODE_LIGHT;
      off_o   <= '0;
    end else begin
      req_q   <= req_i;
      valid_o <= req_rise;
      if (req_rise) begin
        off_o   <= off_d;
        sleep_o <= (off_d != '0);
        mode_o  <= (off_d > thr_i) ? MODE_DEEP : MODE_LIGHT;
      end
    end
  end
endmodule

// File: rtl/sleep_depth_sel.sv
module sleep_depth_sel #(
  parameter int CNT_W     = 16,
  parameter int THR_RESET = 55
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] period_i,
  input  logic             core_active_i,
  input  logic             sleep_req_i,
  input  logic             thr_we_i,
  input  logic [CNT_W-1:0] thr_data_i,
  output logic             valid_o,
  output logic             sleep_o,
  output logic             mode_o,
  output logic [CNT_W-1:0] off_pred_o
);
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    thr;
  sds_pkg::sleep_mode_e mode;

  on_time_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(core_active_i),
    .period_i(period_i),
    .cnt_o   (cnt)
  );

  thr_reg #(.CNT_W(CNT_W), .THR_RESET(THR_RESET)) u_thr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (thr_we_i),
    .data_i(thr_data_i),
    .thr_o (thr)
  );

  depth_decider #(.CNT_W(CNT_W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (sleep_req_i),
    .period_i(period_i),
    .cnt_i   (cnt),
    .thr_i   (thr),
    .valid_o (valid_o),
    .sleep_o (sleep_o),
    .mode_o  (mode),
    .off_o   (off_pred_o)
  );

  assign mode_o = mode;
endmodule

// File: rtl/sds_checker.sv
module sds_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] period_i,
  input logic             sleep_req_i,
  input logic             valid_o,
  input logic             sleep_o,
  input logic             mode_o,
  input logic [CNT_W-1:0] off_pred_o
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R8

  AST_STROBE_ON_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sleep_req_i) |=> valid_o); // R8

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(off_pred_o) && $stable(mode_o) && $stable(sleep_o))); // R8

  AST_OFF_WITHIN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (off_pred_o <= $past(period_i))); // R4

  AST_ZERO_STAYS_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (sleep_o == (off_pred_o != '0))); // R5

  AST_DEEP_NEEDS_TIME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && mode_o) |-> sleep_o); // R6
endmodule

bind sleep_depth_sel sds_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .period_i   (period_i),
  .sleep_req_i(sleep_req_i),
  .valid_o    (valid_o),
  .sleep_o    (sleep_o),
  .mode_o     (mode_o),
  .off_pred_o (off_pred_o)
);

// File: tb/sleep_depth_sel_test.sv
`timescale 1ns/1ps
module sleep_depth_sel_test;
  localparam int CNT_W = 8;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] period_i = 8'd100;
  logic             core_active_i = 1'b0;
  logic             sleep_req_i = 1'b0;
  logic             thr_we_i = 1'b0;
  logic [CNT_W-1:0] thr_data_i = '0;
  logic             valid_o, sleep_o, mode_o;
  logic [CNT_W-1:0] off_pred_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  sleep_depth_sel #(.CNT_W(CNT_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .period_i(period_i),
    .core_active_i(core_active_i), .sleep_req_i(sleep_req_i),
    .thr_we_i(thr_we_i), .thr_data_i(thr_data_i),
    .valid_o(valid_o), .sleep_o(sleep_o), .mode_o(mode_o),
    .off_pred_o(off_pred_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_active(input int n);
    core_active_i = 1'b1;
    repeat (n) @(negedge clk_i);
    core_active_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // raise request, check the decision one edge later, then drop it
  task automatic decide(input string req, input int off, input int slp, input int mode);
    sleep_req_i = 1'b1;
    @(negedge clk_i);
    chk({req, " valid"}, valid_o, 1);
    chk({req, " off"}, off_pred_o, off);
    chk({req, " sleep"}, sleep_o, slp);
    chk({req, " mode"}, mode_o, mode);
    sleep_req_i = 1'b0;
    @(negedge clk_i);
    chk({req, " strobe ends"}, valid_o, 0);
  endtask

  task automatic set_thr(input int v);
    thr_we_i = 1'b1;
    thr_data_i = CNT_W'(v);
    @(negedge clk_i);
    thr_we_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", valid_o, 0);
    chk("R1 sleep", sleep_o, 0);
    chk("R1 mode", mode_o, 0);
    chk("R1 off", off_pred_o, 0);
  endtask

  task automatic t_boundary;
    period_i = 8'd100;
    run_active(45);
    decide("R2 R6 off55 light", 55, 1, 0);
    run_active(44);
    decide("R6 off56 deep", 56, 1, 1);
  endtask

  task automatic t_saturate;
    run_active(100);
    decide("R5 off0 stay active", 0, 0, 0);
    run_active(150);
    decide("R4 past period", 0, 0, 0);
    period_i = 8'd255;
    run_active(300);
    decide("R4 full scale", 0, 0, 0);
    period_i = 8'd100;
  endtask

  task automatic t_restart;
    run_active(90);
    idle(3);
    run_active(10);
    decide("R3 new stretch", 90, 1, 1);
  endtask

  task automatic t_idle_hold;
    run_active(70);
    idle(10);
    decide("R9 count held", 30, 1, 0);
  endtask

  task automatic t_threshold;
    set_thr(80);
    run_active(15);
    decide("R7 off85 thr80", 85, 1, 1);
    run_active(20);
    decide("R7 off80 thr80", 80, 1, 0);
    set_thr(55);
    period_i = 8'd30;
    run_active(5);
    decide("R7 short period", 25, 1, 0);
    period_i = 8'd100;
  endtask

  task automatic t_held_req;
    run_active(10);
    sleep_req_i = 1'b1;
    @(negedge clk_i);
    chk("R8 first strobe", valid_o, 1);
    chk("R8 off", off_pred_o, 90);
    run_active(50);
    chk("R8 held no strobe", valid_o, 0);
    chk("R8 off held", off_pred_o, 90);
    chk("R8 mode held", mode_o, 1);
    sleep_req_i = 1'b0;
    @(negedge clk_i);
    decide("R8 second request", 50, 1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_boundary();
    t_saturate();
    t_restart();
    t_idle_hold();
    t_threshold();
    t_held_req();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule